// File: doc/BRIEF.md
# Soft-Ramped Stereo Digital Volume

This block scales a stereo stream of 24-bit signed samples by a per-channel 8-bit linear gain, just before the samples reach the converter. The gain is the level divided by 255. Level 255 passes the sample unchanged, and level 0 silences it. The level software programs is only a target. The gain actually applied walks toward that target one step at a time, and steps fall only on frame boundaries. A volume change therefore never produces a jump in the output.

A soft-mute control makes both channels walk down to silence and back up again at the same pace. If mute is released partway down, the walk turns around at once from wherever it is. A 2-bit speed mode sets how many frames each step takes. Each channel also has a polarity-inversion control that negates its output, with saturation for the one value that cannot be negated.

Top module: `soft_vol_atten`

## Requirements
- R1: After reset, both applied levels are 255, the frame counter is 0 and both outputs are 0.
- R2: On each cycle with `frame_stb` high, each output is registered as (input × applied level) / 255, truncated toward zero. The applied level used is the one held in that cycle, before any step. The result appears on the output in the following cycle.
- R3: The applied levels step once every 4, 8 or 16 strobes for speed 00, 01 or 10, and speed 11 behaves as 10. Starting from counter 0, a full ramp from 255 to 0 completes on strobe 1020 (speed 00) or strobe 4080 (speed 10).
- R4: At each step, an applied level moves by exactly one toward its target and never passes it. A target that changes in the middle of a ramp is followed from the current applied value.
- R5: While `mute` is high, the target of both channels is 0. While it is low, each target is that channel's programmed level.
- R6: If mute is released before the level reaches 0, the applied level climbs back from its present value without first reaching 0.
- R7: Left and right have independent levels and inversion controls, and one channel's settings never affect the other channel's output.
- R8: With a channel's invert bit set (1 = inverted), its output is the negated scaled value. A result of +8388608 saturates to +8388607.
- R9: Without `frame_stb`, the applied levels, the frame counter and the outputs hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per stereo frame |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| lvl_l | input | 8 | Left programmed level (255 = 0 dB, 0 = silent) |
| lvl_r | input | 8 | Right programmed level |
| mute | input | 1 | Soft mute, 1 = ramp to silence |
| inv_l | input | 1 | Left polarity inversion |
| inv_r | input | 1 | Right polarity inversion |
| speed | input | 2 | Step pacing: 00 = 4, 01 = 8, 10/11 = 16 frames per step |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |

## Verification
The assertions check the following on every cycle:
- No applied level ever moves by more than one.
- Nothing changes without a strobe.
- Levels never rise while muted.
- An upward ramp never passes its target.
- An inverted output never takes the most negative value.

Only the bench's scenarios can show the rest:
- The exact arithmetic of every scaled sample.
- The frame count of a full ramp in each speed mode.
- The immediate reversal when mute is released mid-ramp.
- The independence of the two channels.

The bench reads the applied level through the outputs by feeding a sample of 255000, which comes out as exactly 1000 times the level.

// File: rtl/soft_vol_atten.sv
module soft_vol_atten #(
  parameter int DW = 24,
  parameter int LW = 8,
  parameter int BASE_SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_stb,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  input  logic [LW-1:0]        lvl_l,
  input  logic [LW-1:0]        lvl_r,
  input  logic                 mute,
  input  logic                 inv_l,
  input  logic                 inv_r,
  input  logic [1:0]           speed,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r
);
  localparam int CW = BASE_SHIFT + 3;
  localparam int PW = DW + LW + 1;
  localparam logic [LW-1:0] FULL = {LW{1'b1}};
  localparam logic signed [PW-1:0] DIV = PW'(2**LW - 1);
  localparam logic signed [PW-1:0] POS_MAX = PW'(2**(DW-1) - 1);
  localparam logic signed [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [CW-1:0] ctr;
  logic [LW-1:0] cur_l, cur_r;
  logic [1:0]    sp_eff;
  logic [CW-1:0] last;
  logic          step;
  logic [LW-1:0] tgt_l, tgt_r;

  assign sp_eff = (speed == 2'b11) ? 2'b10 : speed;
  assign last   = CW'((1 << (BASE_SHIFT + int'(sp_eff))) - 1);
  assign step   = frame_stb && (ctr >= last);
  assign tgt_l  = mute ? '0 : lvl_l;
  assign tgt_r  = mute ? '0 : lvl_r;

  function automatic logic [LW-1:0] toward(input logic [LW-1:0] c, input logic [LW-1:0] t);
    if (c < t)      return c + 1'b1;
    else if (c > t) return c - 1'b1;
    else            return c;
  endfunction

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] s,
                                                  input logic [LW-1:0] g,
                                                  input logic inv);
    logic signed [PW-1:0] p, q;
    p = PW'(s) * $signed({1'b0, g});
    q = p / DIV;
    if (inv) q = -q;
    if (q > POS_MAX) q = POS_MAX;
    return q[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr   <= '0;
      cur_l <= FULL;
      cur_r <= FULL;
      out_l <= '0;
      out_r <= '0;
    end else if (frame_stb) begin
      ctr   <= step ? '0 : ctr + 1'b1;
      out_l <= scale(in_l, cur_l, inv_l);
      out_r <= scale(in_r, cur_r, inv_r);
      if (step) begin
        cur_l <= toward(cur_l, tgt_l);
        cur_r <= toward(cur_r, tgt_r);
      end
    end
  end

  AST_STEP_ONE_L: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_l == $past(cur_l) || cur_l == $past(cur_l) + 1'b1 || cur_l == $past(cur_l) - 1'b1)); // R4
  AST_STEP_ONE_R: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_r == $past(cur_r) || cur_r == $past(cur_r) + 1'b1 || cur_r == $past(cur_r) - 1'b1)); // R4
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(cur_l) && $stable(cur_r) && $stable(out_l) && $stable(out_r) && $stable(ctr))); // R9
  AST_MUTE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    mute |=> (cur_l <= $past(cur_l) && cur_r <= $past(cur_r))); // R5
  AST_NO_OVERSHOOT_L: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !mute && cur_l < lvl_l) |=> cur_l <= $past(lvl_l)); // R4
  AST_NO_OVERSHOOT_R: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !mute && cur_r < lvl_r) |=> cur_r <= $past(lvl_r)); // R4
  AST_INV_SAT_L: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && inv_l) |=> out_l != NEG_MIN); // R8
  AST_INV_SAT_R: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && inv_r) |=> out_r != NEG_MIN); // R8
endmodule

// File: tb/test_soft_vol_atten.sv
`timescale 1ns/1ps
module test_soft_vol_atten;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic [7:0] lvl_l = 8'd255, lvl_r = 8'd255;
  logic mute = 1'b0, inv_l = 1'b0, inv_r = 1'b0;
  logic [1:0] speed = 2'b00;
  logic signed [23:0] out_l, out_r;

  int checks = 0, errors = 0;
  int mctr = 0, ml = 255, mr = 255;
  bit done = 0;

  always #2 clk = ~clk;

  soft_vol_atten i_soft_vol_atten (
    .clk(clk), .rst_n(rst_n), .frame_stb(stb), .in_l(in_l), .in_r(in_r),
    .lvl_l(lvl_l), .lvl_r(lvl_r), .mute(mute), .inv_l(inv_l), .inv_r(inv_r),
    .speed(speed), .out_l(out_l), .out_r(out_r));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint expv(input logic signed [23:0] s, input int lv, input bit inv);
    longint q;
    q = (longint'(s) * lv) / 255;
    if (inv) q = -q;
    if (q > 8388607) q = 8388607;
    return q;
  endfunction

  function automatic int walk(input int c, input int t);
    if (c < t) return c + 1;
    if (c > t) return c - 1;
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mctr = 0; ml = 255; mr = 255;
  endtask

  task automatic frame(input logic signed [23:0] a, input logic signed [23:0] b, input string tag);
    longint el, er;
    int per;
    @(negedge clk);
    in_l = a; in_r = b; stb = 1'b1;
    el = expv(a, ml, inv_l);
    er = expv(b, mr, inv_r);
    per = 4 << ((speed == 2'b11) ? 2 : int'(speed));
    if (mctr >= per - 1) begin
      mctr = 0;
      ml = walk(ml, mute ? 0 : int'(lvl_l));
      mr = walk(mr, mute ? 0 : int'(lvl_r));
    end else mctr++;
    @(negedge clk);
    stb = 1'b0;
    chk({tag, " left"}, out_l, el);
    chk({tag, " right"}, out_r, er);
  endtask

  function automatic logic signed [23:0] pat(input int k);
    logic [31:0] h;
    if (k % 29 == 0) return 24'sh800000;
    if (k % 31 == 0) return 24'sh7FFFFF;
    h = 32'(k) * 32'd2654435761;
    return h[27:4];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset out_l", out_l, 0);
    chk("R1 reset out_r", out_r, 0);
    rst_n = 1'b1;
    // R1: applied level starts at 255, visible as 1000*255
    frame(24'sd255000, 24'sd255000, "R1 initial level");

    // R9: inputs move without strobe, outputs hold
    @(negedge clk); in_l = 24'sd12345; in_r = -24'sd777; lvl_l = 8'd0; mute = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 hold left", out_l, 255000);
    chk("R9 hold right", out_r, 255000);
    mute = 1'b0; lvl_l = 8'd255;

    // R3 full ramp at speed 00: 1020 strobes from counter 0
    do_reset(); speed = 2'b00; mute = 1'b1;
    for (int f = 1; f <= 1021; f++) begin
      frame(24'sd255000, 24'sd255000, "R3 R5 normal ramp");
      if (f == 1020) chk("R3 level 1 at strobe 1020", out_l, 1000);
      if (f == 1021) chk("R3 level 0 after strobe 1020", out_r, 0);
    end

    // R6: release mid-ramp, speed 01
    do_reset(); speed = 2'b01; mute = 1'b1;
    for (int f = 0; f < 400; f++) frame(pat(f), pat(f + 7), "R2 R5 double mute");
    chk("R6 still above zero", ml, 205);
    mute = 1'b0;
    for (int f = 0; f < 500; f++) begin
      frame(24'sd255000, 24'sd255000, "R6 reverse");
      if (f > 0) chk("R6 never reached zero", (out_l == 0) ? 1 : 0, 0);
    end

    // R4 R7: independent targets, mid-ramp target change, both directions
    do_reset(); speed = 2'b00; lvl_l = 8'd200; lvl_r = 8'd250;
    for (int f = 0; f < 120; f++) frame(pat(f), pat(f + 3), "R4 R7 level change");
    lvl_l = 8'd240; lvl_r = 8'd10;
    for (int f = 0; f < 1100; f++) frame(pat(f + 11), pat(f + 5), "R2 R4 R7 retarget");
    chk("R4 left settled", ml, 240);
    chk("R4 right settled", mr, 10);

    // R8: inversion and saturation
    inv_l = 1'b1; lvl_l = 8'd255;
    for (int f = 0; f < 80; f++) frame(pat(f), pat(f + 1), "R8 R7 invert left only");
    chk("R8 left back to full", ml, 255);
    frame(24'sh800000, 24'sh800000, "R8 saturate");
    chk("R8 saturated value", out_l, 8388607);
    inv_r = 1'b1; inv_l = 1'b0;
    for (int f = 0; f < 60; f++) frame(pat(f + 2), pat(f + 9), "R8 invert right");
    inv_r = 1'b0;

    // R3 quad pacing, and speed 11 behaving as quad
    do_reset(); speed = 2'b10; mute = 1'b1;
    for (int f = 1; f <= 4081; f++) begin
      frame(24'sd255000, -24'sd255000, "R3 quad ramp");
      if (f == 4080) chk("R3 quad level 1 at strobe 4080", out_l, 1000);
      if (f == 4081) chk("R3 quad level 0", out_l, 0);
    end
    speed = 2'b11; mute = 1'b0;
    for (int f = 0; f < 200; f++) frame(pat(f), pat(f + 4), "R3 speed 11 as quad");

    // R2 sweep of inputs across levels at speed 00
    do_reset(); speed = 2'b00; mute = 1'b1;
    for (int f = 0; f < 1100; f++) frame(pat(f * 3 + 1), pat(f * 5 + 2), "R2 sweep");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule